// File: doc/BRIEF.md
# AES-128 Iterative Block Encryptor

This block enciphers a single 128-bit plaintext block under a 128-bit cipher key, using the ten-round AES-128 schedule. A single shared round datapath performs one round per clock. The next round key is derived on the fly from the current one, so no expanded key table is stored. The S-box is computed from GF(2^8) arithmetic: a multiplicative inverse found through an exponent chain, followed by the affine map.

Use is a two-step handshake. While `load_i` is high, the plaintext and key buses are captured. Later, with `load_i` low, a rising edge on `start_i` launches the rounds. When the tenth round ends, `done_o` rises, `cipher_o` holds the ciphertext, and `final_key_o` holds the round-10 key, which a separate decryptor can start from. All of these hold until the next load.

The controller has four states. ST_IDLE is the state after reset. ST_ARMED means inputs are captured. ST_ROUND means rounds are in progress. ST_DONE means the result is valid. The transitions are:
- ST_IDLE→ST_ARMED on load.
- ST_ARMED→ST_ARMED on load (recapture).
- ST_ARMED→ST_ROUND on a start rise with load low.
- ST_ROUND→ST_ROUND while the round count is below 10.
- ST_ROUND→ST_DONE after round 10.
- ST_DONE→ST_ARMED on load.

Top module: `aes128_enc_core`

## Requirements
- R1: After reset, `done_o` is 0 and both `cipher_o` and `final_key_o` are all zeros.
- R2: A cycle with `load_i` high outside ST_ROUND captures `text_i` and `key_i` and clears `done_o` on the following edge.
- R3: A rise of `start_i` is ignored unless inputs have been loaded and no run has completed since the last load. After reset with no load, `done_o` stays 0 and `cipher_o` stays zero.
- R4: `done_o` stays 0 throughout a run and becomes 1 after the 11th rising clock edge, counting the edge that first samples `start_i` high.
- R5: Byte i of a 128-bit bus is bits [127-8i -: 8], with bit 7 as MSB. State byte S[r,c] is byte r+4c. The sequence is an initial key addition, nine full rounds, and a last round without MixColumns. Key 000102030405060708090a0b0c0d0e0f with plaintext 00112233445566778899aabbccddeeff yields 69c4e0d86a7b0430d8cdb78070b4c55a.
- R6: When `done_o` is 1, `final_key_o` equals the round-10 key of the schedule (RotWord, SubWord, round constants 01,02,04,08,10,20,40,80,1b,36).
- R7: In ST_DONE, until the next load, `done_o` stays 1 and `cipher_o` stays unchanged, and a new rise of `start_i` starts nothing.
- R8: `load_i` high during ST_ROUND is ignored: the run finishes with the ciphertext of the data and key loaded before the start.
- R9: Holding `start_i` high does not restart a run. Only a 0→1 transition is a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture strobe for text and key |
| start_i | input | 1 | Run strobe; its rising edge launches the rounds |
| text_i | input | 128 | Plaintext block |
| key_i | input | 128 | Cipher key |
| cipher_o | output | 128 | Ciphertext register |
| final_key_o | output | 128 | Round-10 key, for a later decryptor |
| done_o | output | 1 | Result valid |

## Verification
Load takes effect on the first edge after `load_i` is seen, so `done_o` is already low at the following falling edge. After the edge that samples the start rise, `done_o` is checked low at each of the next ten falling edges and high at the eleventh. The ciphertext and final key are compared at that same falling edge. All inputs change on falling edges and all outputs are sampled there, half a period clear of any active edge.

// File: rtl/aes_pkg.sv
package aes_pkg;
    localparam int BLK_W   = 128;
    localparam int NBYTES  = BLK_W / 8;
    localparam int NCOL    = 4;
    localparam int NROUNDS = 10;
    localparam int RND_W   = $clog2(NROUNDS + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_ROUND,
        ST_DONE
    } enc_fsm_t;

    function automatic logic [7:0] gf_x2(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_x2(sh);
        end
        return acc;
    endfunction
endpackage

// File: rtl/aes_sbox.sv
module aes_sbox
    import aes_pkg::*;
(
    input  logic [7:0] a_i,
    output logic [7:0] y_o
);
    logic [7:0] p2, p3, p6, p7, p14, p15, p30, p31, p62, p63, p126, p127, inv;

    always_comb begin
        p2   = gf_mul(a_i, a_i);
        p3   = gf_mul(p2, a_i);
        p6   = gf_mul(p3, p3);
        p7   = gf_mul(p6, a_i);
        p14  = gf_mul(p7, p7);
        p15  = gf_mul(p14, a_i);
        p30  = gf_mul(p15, p15);
        p31  = gf_mul(p30, a_i);
        p62  = gf_mul(p31, p31);
        p63  = gf_mul(p62, a_i);
        p126 = gf_mul(p63, p63);
        p127 = gf_mul(p126, a_i);
        inv  = gf_mul(p127, p127);
        y_o  = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                   ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    end
endmodule

// File: rtl/aes_keystep.sv
module aes_keystep
    import aes_pkg::*;
(
    input  logic [BLK_W-1:0] key_i,
    input  logic [7:0]       rcon_i,
    output logic [BLK_W-1:0] key_o
);
    logic [31:0] w0, w1, w2, w3, rot, sub, n0, n1, n2, n3;

    assign w0  = key_i[127:96];
    assign w1  = key_i[95:64];
    assign w2  = key_i[63:32];
    assign w3  = key_i[31:0];
    assign rot = {w3[23:0], w3[31:24]};

    for (genvar b = 0; b < 4; b++) begin : g_sub
        aes_sbox u_sb (.a_i(rot[8*b +: 8]), .y_o(sub[8*b +: 8]));
    end

    assign n0    = w0 ^ sub ^ {rcon_i, 24'h000000};
    assign n1    = w1 ^ n0;
    assign n2    = w2 ^ n1;
    assign n3    = w3 ^ n2;
    assign key_o = {n0, n1, n2, n3};
endmodule

// File: rtl/aes_round.sv
module aes_round
    import aes_pkg::*;
(
    input  logic [BLK_W-1:0] st_i,
    input  logic [BLK_W-1:0] rk_i,
    input  logic             last_i,
    output logic [BLK_W-1:0] st_o
);
    logic [7:0] sb [NBYTES];
    logic [7:0] sh [NBYTES];
    logic [7:0] mc [NBYTES];

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        localparam int ROW = k % 4;
        localparam int COL = k / 4;
        localparam int SRC = ROW + 4 * ((COL + ROW) % NCOL);
        aes_sbox u_sb (.a_i(st_i[BLK_W-1-8*k -: 8]), .y_o(sb[k]));
        assign sh[k] = sb[SRC];
    end

    for (genvar c = 0; c < NCOL; c++) begin : g_mix
        logic [7:0] a0, a1, a2, a3;
        assign a0 = sh[4*c];
        assign a1 = sh[4*c+1];
        assign a2 = sh[4*c+2];
        assign a3 = sh[4*c+3];
        assign mc[4*c]   = gf_x2(a0) ^ gf_x2(a1) ^ a1 ^ a2 ^ a3;
        assign mc[4*c+1] = a0 ^ gf_x2(a1) ^ gf_x2(a2) ^ a2 ^ a3;
        assign mc[4*c+2] = a0 ^ a1 ^ gf_x2(a2) ^ gf_x2(a3) ^ a3;
        assign mc[4*c+3] = gf_x2(a0) ^ a0 ^ a1 ^ a2 ^ gf_x2(a3);
    end

    for (genvar k = 0; k < NBYTES; k++) begin : g_ark
        assign st_o[BLK_W-1-8*k -: 8] = (last_i ? sh[k] : mc[k]) ^ rk_i[BLK_W-1-8*k -: 8];
    end
endmodule

// File: rtl/aes128_enc_core.sv
module aes128_enc_core
    import aes_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         start_i,
    input  logic [127:0] text_i,
    input  logic [127:0] key_i,
    output logic [127:0] cipher_o,
    output logic [127:0] final_key_o,
    output logic         done_o
);
    enc_fsm_t           state_q, state_d;
    logic               start_q;
    logic               start_rise;
    logic [BLK_W-1:0]   din_q, kin_q, st_q, rk_q, res_q, fkey_q;
    logic [BLK_W-1:0]   rnd_out, key_next;
    logic [7:0]         rcon_q;
    logic [RND_W-1:0]   rnd_q;
    logic               done_q;
    logic               last_rnd;

    assign start_rise = start_i & ~start_q;
    assign last_rnd   = (rnd_q == RND_W'(NROUNDS));

    aes_keystep u_key (.key_i(rk_q), .rcon_i(rcon_q), .key_o(key_next));
    aes_round   u_rnd (.st_i(st_q), .rk_i(key_next), .last_i(last_rnd), .st_o(rnd_out));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (load_i) state_d = ST_ARMED;
            ST_ARMED: if (!load_i && start_rise) state_d = ST_ROUND;
            ST_ROUND: if (last_rnd) state_d = ST_DONE;
            ST_DONE:  if (load_i) state_d = ST_ARMED;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            din_q   <= '0;
            kin_q   <= '0;
            st_q    <= '0;
            rk_q    <= '0;
            res_q   <= '0;
            fkey_q  <= '0;
            rcon_q  <= 8'h01;
            rnd_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            start_q <= start_i;
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (load_i) begin
                        din_q  <= text_i;
                        kin_q  <= key_i;
                        done_q <= 1'b0;
                    end
                end
                ST_ARMED: begin
                    if (load_i) begin
                        din_q <= text_i;
                        kin_q <= key_i;
                    end else if (start_rise) begin
                        st_q   <= din_q ^ kin_q;
                        rk_q   <= kin_q;
                        rcon_q <= 8'h01;
                        rnd_q  <= RND_W'(1);
                    end
                end
                ST_ROUND: begin
                    st_q   <= rnd_out;
                    rk_q   <= key_next;
                    rcon_q <= gf_x2(rcon_q);
                    rnd_q  <= rnd_q + RND_W'(1);
                    if (last_rnd) begin
                        res_q  <= rnd_out;
                        fkey_q <= key_next;
                        done_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign cipher_o    = res_q;
    assign final_key_o = fkey_q;
    assign done_o      = done_q;

    a_r4_no_done_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ROUND) |-> !done_o);
    a_r4_round_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ROUND) |-> (rnd_q >= RND_W'(1) && rnd_q <= RND_W'(NROUNDS)));
    a_r2_load_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && state_q != ST_ROUND) |=> !done_o);
    a_r7_done_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !load_i) |=> (done_o && $stable(cipher_o) && $stable(final_key_o)));
    a_r8_load_ignored_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ROUND) |=> ($stable(din_q) && $stable(kin_q)));
    a_r3_start_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (state_q != ST_ROUND));
endmodule

// File: tb/sim_aes128_enc_core.sv
module sim_aes128_enc_core;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic         start_i = 1'b0;
    logic [127:0] text_i = '0;
    logic [127:0] key_i = '0;
    logic [127:0] cipher_o, final_key_o;
    logic         done_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [7:0] sbox_t [256];

    aes128_enc_core u0 (.*);

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [7:0] rf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p = 16'h0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] rf_x2(input logic [7:0] a);
        return rf_mul(a, 8'h02);
    endfunction

    function automatic logic [127:0] ref_next_key(input logic [127:0] k, input logic [7:0] rc);
        logic [31:0] w [4];
        logic [31:0] t;
        for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
        t = {sbox_t[w[3][23:16]] ^ rc, sbox_t[w[3][15:8]], sbox_t[w[3][7:0]], sbox_t[w[3][31:24]]};
        w[0] = w[0] ^ t;
        for (int i = 1; i < 4; i++) w[i] = w[i] ^ w[i-1];
        return {w[0], w[1], w[2], w[3]};
    endfunction

    function automatic logic [127:0] ref_last_key(input logic [127:0] k);
        logic [7:0] rc = 8'h01;
        logic [127:0] rk = k;
        for (int r = 0; r < 10; r++) begin
            rk = ref_next_key(rk, rc);
            rc = rf_x2(rc);
        end
        return rk;
    endfunction

    function automatic logic [127:0] ref_encrypt(input logic [127:0] pt, input logic [127:0] k);
        logic [7:0] s [16];
        logic [7:0] t [16];
        logic [7:0] rc = 8'h01;
        logic [127:0] rk = k;
        logic [127:0] res;
        for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ k[127-8*i -: 8];
        for (int r = 1; r <= 10; r++) begin
            rk = ref_next_key(rk, rc);
            rc = rf_x2(rc);
            for (int row = 0; row < 4; row++)
                for (int col = 0; col < 4; col++)
                    t[row + 4*col] = sbox_t[s[row + 4*((col + row) % 4)]];
            for (int col = 0; col < 4; col++) begin
                if (r < 10) begin
                    s[4*col]   = rf_mul(t[4*col],8'h02)^rf_mul(t[4*col+1],8'h03)^t[4*col+2]^t[4*col+3];
                    s[4*col+1] = t[4*col]^rf_mul(t[4*col+1],8'h02)^rf_mul(t[4*col+2],8'h03)^t[4*col+3];
                    s[4*col+2] = t[4*col]^t[4*col+1]^rf_mul(t[4*col+2],8'h02)^rf_mul(t[4*col+3],8'h03);
                    s[4*col+3] = rf_mul(t[4*col],8'h03)^t[4*col+1]^t[4*col+2]^rf_mul(t[4*col+3],8'h02);
                end else begin
                    for (int j = 0; j < 4; j++) s[4*col+j] = t[4*col+j];
                end
            end
            for (int i = 0; i < 16; i++) s[i] = s[i] ^ rk[127-8*i -: 8];
        end
        for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
        return res;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [127:0] d, input logic [127:0] k);
        @(negedge clk);
        load_i = 1'b1; text_i = d; key_i = k;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    // raise start, check done low for ten falling edges, high at the eleventh
    task automatic run_check(input logic [127:0] d, input logic [127:0] k, input string tag);
        logic early = 1'b0;
        @(negedge clk);
        start_i = 1'b1;
        for (int e = 0; e < 10; e++) begin
            @(negedge clk);
            if (done_o) early = 1'b1;
        end
        chk({"R4 done low during run ", tag}, 128'(early), 128'(0));
        @(negedge clk);
        chk({"R4 done after 11 edges ", tag}, 128'(done_o), 128'(1));
        chk({"R5 ciphertext ", tag}, cipher_o, ref_encrypt(d, k));
        chk({"R6 final key ", tag}, final_key_o, ref_last_key(k));
        start_i = 1'b0;
    endtask

    initial begin
        logic [127:0] d, k, d2, held;
        int seed_dummy;
        // reference S-box: brute-force inverse plus affine map
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 8'h00;
            for (int y = 1; y < 256; y++)
                if (rf_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            sbox_t[x] = inv ^ {inv[6:0],inv[7]} ^ {inv[5:0],inv[7:6]}
                        ^ {inv[4:0],inv[7:5]} ^ {inv[3:0],inv[7:4]} ^ 8'h63;
        end
        seed_dummy = $urandom(32'd20240611);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset done", 128'(done_o), 128'(0));
        chk("R1 reset cipher", cipher_o, '0);
        chk("R1 reset final key", final_key_o, '0);

        // R3: start without any load does nothing
        start_i = 1'b1;
        repeat (15) @(negedge clk);
        chk("R3 no run without load done", 128'(done_o), 128'(0));
        chk("R3 no run without load cipher", cipher_o, '0);
        start_i = 1'b0;

        // R5 standard vector
        d = 128'h00112233445566778899aabbccddeeff;
        k = 128'h000102030405060708090a0b0c0d0e0f;
        do_load(d, k);
        run_check(d, k, "fips");
        chk("R5 fixed ciphertext", cipher_o, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        chk("R6 fixed final key", final_key_o, 128'h13111d7fe3944a17f307a78b4d2b30c5);

        // R7: hold and restart ignored in done
        held = cipher_o;
        repeat (3) @(negedge clk);
        start_i = 1'b1;
        begin
            logic dropped = 1'b0;
            for (int e = 0; e < 14; e++) begin
                @(negedge clk);
                if (!done_o) dropped = 1'b1;
            end
            chk("R7 done held through start", 128'(dropped), 128'(0));
        end
        chk("R7 cipher held", cipher_o, held);
        start_i = 1'b0;

        // R2: load clears done on the next edge
        d = {$urandom, $urandom, $urandom, $urandom};
        k = {$urandom, $urandom, $urandom, $urandom};
        @(negedge clk);
        load_i = 1'b1; text_i = d; key_i = k;
        @(negedge clk);
        load_i = 1'b0;
        chk("R2 load clears done", 128'(done_o), 128'(0));
        // R2 recapture while armed: last load wins
        d = {$urandom, $urandom, $urandom, $urandom};
        do_load(d, k);
        run_check(d, k, "recapture");

        // R9: start held high, no retrigger after load
        d = {$urandom, $urandom, $urandom, $urandom};
        do_load(d, k);
        run_check(d, k, "r9_first");
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        load_i = 1'b1; text_i = ~d;
        @(negedge clk);
        load_i = 1'b0;
        repeat (15) @(negedge clk);
        chk("R9 held start no run", 128'(done_o), 128'(0));
        start_i = 1'b0;
        run_check(~d, k, "r9_after_drop");

        // R8: load during run ignored
        d = {$urandom, $urandom, $urandom, $urandom};
        k = {$urandom, $urandom, $urandom, $urandom};
        do_load(d, k);
        @(negedge clk);
        start_i = 1'b1;
        repeat (4) @(negedge clk);
        load_i = 1'b1; text_i = ~d; key_i = ~k;
        @(negedge clk);
        load_i = 1'b0;
        repeat (6) @(negedge clk);
        chk("R8 done after run with load", 128'(done_o), 128'(1));
        chk("R8 ciphertext of original load", cipher_o, ref_encrypt(d, k));
        start_i = 1'b0;

        // corner patterns and random vectors
        do_load('0, '0);
        run_check('0, '0, "zeros");
        do_load('1, '1);
        run_check('1, '1, "ones");
        for (int n = 0; n < 20; n++) begin
            d = {$urandom, $urandom, $urandom, $urandom};
            k = {$urandom, $urandom, $urandom, $urandom};
            do_load(d, k);
            repeat ($urandom_range(0, 3)) @(negedge clk);
            run_check(d, k, "random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule